// File: doc/BRIEF.md
# Wave Lane-Mask Predicate Unit

This unit sits next to a wave's vector register file. It turns a compact mask operand into the per-lane enable mask for one wave instruction. It then reduces that mask to the whole-wave results that control flow and predicated moves need. The operand names two mask registers, each with an invert flag. The unit sends the two register numbers to the register file and receives bit 0 of every lane of each register. It inverts each source when asked and ANDs the two together.

From the combined mask it computes four results. The all-lanes and any-lane branch conditions are one bit each. The select result is a per-lane choice between a "false" vector and a "true" vector. The first-true scalar is the element of the true vector taken from the lowest lane whose mask bit is set, with a write enable. When no lane is set, the write enable stays low and the scalar output keeps its old value. All results pass through one output register, so they appear one clock after the instruction is presented.

Top module: `wave_pred_unit`

## Requirements
- R1: The read indices are decoded combinationally from the 12-bit operand: `rd_idx_a` = operand[4:0] and `rd_idx_b` = operand[10:6]. Bit 5 inverts source A and bit 11 inverts source B.
- R2: One cycle after an accepted instruction, `lane_mask` bit i equals (A bit i XOR invert-A) AND (B bit i XOR invert-B).
- R3: `br_all` is 1 exactly when every lane of the combined mask is 1.
- R4: `br_any` is 1 exactly when at least one lane of the combined mask is 1.
- R5: Lane i of `sel_vec` equals lane i of `vec_true` where the mask bit is 1, and lane i of `vec_false` where it is 0. Lane i occupies bits [i*DATA_W +: DATA_W].
- R6: For a first-true instruction (`in_first`=1) with a nonzero mask, `scalar_we` is 1 and `scalar_out` is the `vec_true` element of the lowest-indexed set lane.
- R7: For a first-true instruction with an all-zero mask, `scalar_we` is 0 and `scalar_out` keeps its previous value. `scalar_out` changes only in cycles where `scalar_we` is 1.
- R8: `out_valid` equals `in_valid` delayed by one cycle. In a cycle without a valid instruction, `scalar_we` is 0.
- R9: During and right after a synchronous active-high reset, all registered outputs are 0.
- R10: `scalar_we` is never raised for an instruction with `in_first`=0, whatever its mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction presented this cycle |
| in_first | input | 1 | Instruction is a first-true scalar extract |
| in_opnd | input | 12 | Mask operand (two indices with invert flags) |
| rd_idx_a | output | 5 | Register number for mask source A |
| rd_idx_b | output | 5 | Register number for mask source B |
| mreg_a_bits | input | LANES | Bit 0 of each lane of source A |
| mreg_b_bits | input | LANES | Bit 0 of each lane of source B |
| vec_false | input | LANES*DATA_W | Vector chosen where the mask is 0 |
| vec_true | input | LANES*DATA_W | Vector chosen where the mask is 1; first-true value source |
| out_valid | output | 1 | Results valid |
| lane_mask | output | LANES | Combined lane mask |
| br_all | output | 1 | Every lane set |
| br_any | output | 1 | Some lane set |
| sel_vec | output | LANES*DATA_W | Per-lane select result |
| scalar_out | output | DATA_W | First-true scalar (held when not written) |
| scalar_we | output | 1 | Scalar write enable |

## Verification
The bench builds the unit with LANES=8 and DATA_W=16. With only eight lanes, the all-set case that raises the all-lanes branch comes up often in random operands. Single top-lane and bottom-lane masks are also easy to set up, so the priority encoder's extremes are exercised. The narrow lanes keep the flattened vectors small while every select lane stays distinguishable. All 32 register numbers and both invert flags are still reachable, because the operand width does not depend on LANES.

// File: rtl/wpu_pkg.sv
package wpu_pkg;
  parameter int unsigned WPU_IDX_W = 5;

  typedef struct packed {
    logic                 inv_b;
    logic [WPU_IDX_W-1:0] idx_b;
    logic                 inv_a;
    logic [WPU_IDX_W-1:0] idx_a;
  } mask_opnd_t;

  localparam int unsigned WPU_OPND_W = $bits(mask_opnd_t);
endpackage

// File: rtl/wpu_mask_combine.sv
module wpu_mask_combine #(
  parameter int unsigned LANES = 32
) (
  input  logic [LANES-1:0] src_a,
  input  logic [LANES-1:0] src_b,
  input  logic             inv_a,
  input  logic             inv_b,
  output logic [LANES-1:0] mask
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign mask[g] = (src_a[g] ^ inv_a) & (src_b[g] ^ inv_b);
  end
endmodule

// File: rtl/wpu_first_lane.sv
module wpu_first_lane #(
  parameter int unsigned LANES = 32,
  localparam int unsigned LIDX_W = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic [LANES-1:0]  req,
  output logic              found,
  output logic [LIDX_W-1:0] idx
);
  // scan from the top so the lowest set lane wins
  always_comb begin
    idx = '0;
    for (int i = LANES - 1; i >= 0; i--) begin
      if (req[i]) idx = LIDX_W'(i);
    end
  end
  assign found = |req;
endmodule

// File: rtl/wpu_lane_select.sv
module wpu_lane_select #(
  parameter int unsigned LANES  = 32,
  parameter int unsigned DATA_W = 32
) (
  input  logic [LANES-1:0]        mask,
  input  logic [LANES*DATA_W-1:0] v_false,
  input  logic [LANES*DATA_W-1:0] v_true,
  output logic [LANES*DATA_W-1:0] v_out
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign v_out[g*DATA_W +: DATA_W] = mask[g] ? v_true[g*DATA_W +: DATA_W]
                                               : v_false[g*DATA_W +: DATA_W];
  end
endmodule

// File: rtl/wave_pred_unit.sv
module wave_pred_unit
  import wpu_pkg::*;
#(
  parameter int unsigned LANES  = 32,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned VEC_W = LANES * DATA_W,
  localparam int unsigned LIDX_W = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  in_valid,
  input  logic                  in_first,
  input  logic [WPU_OPND_W-1:0] in_opnd,
  output logic [WPU_IDX_W-1:0]  rd_idx_a,
  output logic [WPU_IDX_W-1:0]  rd_idx_b,
  input  logic [LANES-1:0]      mreg_a_bits,
  input  logic [LANES-1:0]      mreg_b_bits,
  input  logic [VEC_W-1:0]      vec_false,
  input  logic [VEC_W-1:0]      vec_true,
  output logic                  out_valid,
  output logic [LANES-1:0]      lane_mask,
  output logic                  br_all,
  output logic                  br_any,
  output logic [VEC_W-1:0]      sel_vec,
  output logic [DATA_W-1:0]     scalar_out,
  output logic                  scalar_we
);
  mask_opnd_t        opnd;
  logic [LANES-1:0]  mask_c;
  logic [VEC_W-1:0]  sel_c;
  logic              any_c;
  logic [LIDX_W-1:0] first_idx;
  logic [DATA_W-1:0] true_lane [LANES];
  logic              wr_c;

  assign opnd     = mask_opnd_t'(in_opnd);
  assign rd_idx_a = opnd.idx_a;
  assign rd_idx_b = opnd.idx_b;

  wpu_mask_combine #(.LANES(LANES)) u_combine (
    .src_a (mreg_a_bits),
    .src_b (mreg_b_bits),
    .inv_a (opnd.inv_a),
    .inv_b (opnd.inv_b),
    .mask  (mask_c)
  );

  wpu_first_lane #(.LANES(LANES)) u_first (
    .req   (mask_c),
    .found (any_c),
    .idx   (first_idx)
  );

  wpu_lane_select #(.LANES(LANES), .DATA_W(DATA_W)) u_select (
    .mask    (mask_c),
    .v_false (vec_false),
    .v_true  (vec_true),
    .v_out   (sel_c)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_true
    assign true_lane[g] = vec_true[g*DATA_W +: DATA_W];
  end

  assign wr_c = in_valid & in_first & any_c;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      lane_mask  <= '0;
      br_all     <= 1'b0;
      br_any     <= 1'b0;
      sel_vec    <= '0;
      scalar_out <= '0;
      scalar_we  <= 1'b0;
    end else begin
      out_valid <= in_valid;
      scalar_we <= wr_c;
      if (in_valid) begin
        lane_mask <= mask_c;
        br_all    <= &mask_c;
        br_any    <= any_c;
        sel_vec   <= sel_c;
      end
      if (wr_c) scalar_out <= true_lane[first_idx];
    end
  end
endmodule

// File: rtl/wpu_pred_checks.sv
module wpu_pred_checks #(
  parameter int unsigned LANES  = 32,
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              in_first,
  input logic              out_valid,
  input logic [LANES-1:0]  lane_mask,
  input logic              br_all,
  input logic              br_any,
  input logic [DATA_W-1:0] scalar_out,
  input logic              scalar_we
);
  assert_all_lanes_R3: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (br_all == (lane_mask == {LANES{1'b1}})));

  assert_any_lane_R4: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (br_any == ($countones(lane_mask) != 0)));

  assert_write_needs_lane_R6: assert property (@(posedge clk) disable iff (rst)
    scalar_we |-> (lane_mask != '0));

  assert_scalar_held_R7: assert property (@(posedge clk) disable iff (rst)
    !scalar_we |-> $stable(scalar_out));

  assert_valid_follows_R8: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  assert_idle_no_write_R8: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> !scalar_we);

  assert_first_only_R10: assert property (@(posedge clk) disable iff (rst)
    scalar_we |-> $past(in_first));
endmodule

bind wave_pred_unit wpu_pred_checks #(.LANES(LANES), .DATA_W(DATA_W)) u_pred_checks (
  .clk        (clk),
  .rst        (rst),
  .in_valid   (in_valid),
  .in_first   (in_first),
  .out_valid  (out_valid),
  .lane_mask  (lane_mask),
  .br_all     (br_all),
  .br_any     (br_any),
  .scalar_out (scalar_out),
  .scalar_we  (scalar_we)
);

// File: tb/tb_wave_pred_unit.sv
`timescale 1ns/1ps
module tb_wave_pred_unit;
  localparam int LANES  = 8;
  localparam int DATA_W = 16;
  localparam int VEC_W  = LANES * DATA_W;

  typedef struct {
    logic [LANES-1:0]  mask;
    logic              ball;
    logic              bany;
    logic [VEC_W-1:0]  sel;
    logic              we;
    logic [DATA_W-1:0] sc;
  } exp_t;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              in_valid = 1'b0;
  logic              in_first = 1'b0;
  logic [11:0]       in_opnd = '0;
  logic [4:0]        rd_idx_a, rd_idx_b;
  logic [LANES-1:0]  mreg_a_bits = '0;
  logic [LANES-1:0]  mreg_b_bits = '0;
  logic [VEC_W-1:0]  vec_false = '0;
  logic [VEC_W-1:0]  vec_true = '0;
  logic              out_valid, br_all, br_any, scalar_we;
  logic [LANES-1:0]  lane_mask;
  logic [VEC_W-1:0]  sel_vec;
  logic [DATA_W-1:0] scalar_out;

  int n_chk = 0;
  int n_fail = 0;
  exp_t q[$];
  logic [DATA_W-1:0] exp_sc = '0;
  logic [LANES-1:0]  rf [32];

  always #2 clk = ~clk;

  wave_pred_unit #(.LANES(LANES), .DATA_W(DATA_W)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_first(in_first),
    .in_opnd(in_opnd), .rd_idx_a(rd_idx_a), .rd_idx_b(rd_idx_b),
    .mreg_a_bits(mreg_a_bits), .mreg_b_bits(mreg_b_bits),
    .vec_false(vec_false), .vec_true(vec_true), .out_valid(out_valid),
    .lane_mask(lane_mask), .br_all(br_all), .br_any(br_any),
    .sel_vec(sel_vec), .scalar_out(scalar_out), .scalar_we(scalar_we)
  );

  task automatic chk(input string req, input logic [VEC_W-1:0] act, input logic [VEC_W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [11:0] mk(input int ia, input bit na, input int ib, input bit nb);
    return {nb, 5'(ib), na, 5'(ia)};
  endfunction

  // driver: present one instruction, model the expected result, push it
  task automatic drive(input logic [11:0] op, input bit first,
                       input logic [VEC_W-1:0] vf, input logic [VEC_W-1:0] vt);
    exp_t e;
    int ia, ib;
    @(negedge clk);
    in_valid = 1'b1; in_first = first; in_opnd = op;
    vec_false = vf; vec_true = vt;
    ia = int'(op[4:0]); ib = int'(op[10:6]);
    mreg_a_bits = rf[ia]; mreg_b_bits = rf[ib];
    #1;
    chk("R1 idx_a", VEC_W'(rd_idx_a), VEC_W'(op[4:0]));
    chk("R1 idx_b", VEC_W'(rd_idx_b), VEC_W'(op[10:6]));
    for (int i = 0; i < LANES; i++)
      e.mask[i] = (rf[ia][i] ^ op[5]) & (rf[ib][i] ^ op[11]);
    e.ball = (e.mask == {LANES{1'b1}});
    e.bany = (e.mask != '0);
    for (int i = 0; i < LANES; i++)
      e.sel[i*DATA_W +: DATA_W] = e.mask[i] ? vt[i*DATA_W +: DATA_W] : vf[i*DATA_W +: DATA_W];
    e.we = first && e.bany;
    if (e.we) begin
      for (int i = LANES - 1; i >= 0; i--)
        if (e.mask[i]) exp_sc = vt[i*DATA_W +: DATA_W];
    end
    e.sc = exp_sc;
    q.push_back(e);
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0; in_first = 1'b1;
  endtask

  function automatic logic [VEC_W-1:0] ramp(input int base);
    logic [VEC_W-1:0] v;
    for (int i = 0; i < LANES; i++) v[i*DATA_W +: DATA_W] = DATA_W'(base + i * 17);
    return v;
  endfunction

  function automatic logic [VEC_W-1:0] rnd_vec();
    logic [VEC_W-1:0] v;
    for (int i = 0; i < LANES; i++) v[i*DATA_W +: DATA_W] = DATA_W'($urandom);
    return v;
  endfunction

  // monitor / scoreboard
  always @(negedge clk) begin
    if (!rst) begin
      if (out_valid) begin
        if (q.size() == 0) begin
          chk("R8 unexpected valid", VEC_W'(1), VEC_W'(0));
        end else begin
          exp_t e;
          e = q.pop_front();
          chk("R2 lane_mask", VEC_W'(lane_mask), VEC_W'(e.mask));
          chk("R3 br_all", VEC_W'(br_all), VEC_W'(e.ball));
          chk("R4 br_any", VEC_W'(br_any), VEC_W'(e.bany));
          chk("R5 sel_vec", sel_vec, e.sel);
          chk("R6/R7/R10 scalar_we", VEC_W'(scalar_we), VEC_W'(e.we));
          chk("R6/R7 scalar_out", VEC_W'(scalar_out), VEC_W'(e.sc));
        end
      end else begin
        chk("R8 idle no write", VEC_W'(scalar_we), VEC_W'(0));
        chk("R7 idle scalar held", VEC_W'(scalar_out), VEC_W'(exp_sc));
      end
    end
  end

  initial begin
    #(200000 * 4);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    for (int r = 0; r < 32; r++) rf[r] = LANES'(r * 37 + 11) ^ LANES'(r << 3);
    rf[0] = 8'h00; rf[1] = 8'hFF; rf[2] = 8'b1011_0100;
    rf[3] = 8'h80; rf[4] = 8'h01; rf[5] = 8'h0F;

    in_valid = 1'b1;  // held high during reset: must not leak out
    in_first = 1'b1;
    repeat (3) @(negedge clk);
    // R9: reset state
    chk("R9 out_valid", VEC_W'(out_valid), VEC_W'(0));
    chk("R9 lane_mask", VEC_W'(lane_mask), VEC_W'(0));
    chk("R9 br_any", VEC_W'(br_any), VEC_W'(0));
    chk("R9 sel_vec", sel_vec, VEC_W'(0));
    chk("R9 scalar_out", VEC_W'(scalar_out), VEC_W'(0));
    chk("R9 scalar_we", VEC_W'(scalar_we), VEC_W'(0));
    in_valid = 1'b0;
    rst = 1'b0;

    drive(mk(1, 0, 1, 0), 1'b0, ramp(100), ramp(500));  // R3 all set
    drive(mk(0, 1, 0, 1), 1'b0, ramp(7), ramp(900));    // R2 both inverted
    drive(mk(2, 0, 1, 0), 1'b1, ramp(3), ramp(40));     // R6 lowest lane 2
    drive(mk(2, 0, 5, 1), 1'b1, ramp(1), ramp(60));     // R6 lane 4 (0xF0 & 0xB4)
    drive(mk(0, 0, 1, 0), 1'b1, ramp(2), ramp(80));     // R7 empty mask, hold
    drive(mk(3, 0, 1, 0), 1'b1, ramp(5), ramp(300));    // R6 top lane only
    drive(mk(4, 0, 4, 0), 1'b1, ramp(9), ramp(700));    // R6 bottom lane only
    drive(mk(2, 0, 2, 1), 1'b1, ramp(4), ramp(20));     // R7 A & ~A is empty
    drive(mk(1, 0, 2, 0), 1'b0, ramp(11), ramp(33));    // R10 branch op, no write
    idle(); idle();                                      // R8 gap
    drive(mk(5, 0, 2, 1), 1'b0, ramp(50), ramp(1000));  // R5 select pattern
    for (int k = 0; k < 60; k++) begin
      drive(12'($urandom), 1'($urandom), rnd_vec(), rnd_vec());
      if (k % 7 == 3) idle();
    end
    idle(); idle(); idle();
    chk("R8 queue drained", VEC_W'(q.size()), VEC_W'(0));
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule